// File: doc/BRIEF.md
# CCD Electronic Shutter Sequencer

This block decides, line by line and field by field, when the substrate discharge (SUB) pulse of a frame-readout CCD should fire and whether the readout transfer pulses of a field must be held back. It runs on the pixel clock. One-cycle strobes mark each field start (`vd_i`) and each line start (`hd_i`). A shutter setting is written through a load strobe. It holds a 2-bit mode, a field count, a line count and a field selector. A separate pulse generator turns `sub_en_o` into the actual SUB edges inside the enabled line. It also uses `rd_inhibit_o` to drop the ternary readout pulses of the current field.

Lines are numbered from 0 at each field strobe and step by one on every line strobe. The readout line of a field is the index given on `lines_i`. In the short-exposure form, SUB is enabled on the last `shd+1` lines before that index in every field. In the long-exposure form, the exposure covers `svd+1` fields. SUB is enabled only in the one field of that span chosen by `spl`, and new settings are refused until the span ends. A third mode suppresses readout, so that charge keeps integrating through the field.

Top module: `ccd_shutter_seq`

## Requirements
- R1: After reset, `sub_en_o`, `rd_inhibit_o` and `busy_o` are 0 and the stored mode is 00 (stopped) with all counts zero.
- R2: A load strobe while `busy_o` is 0 stores mode, `svd`, `shd` and `spl`, and they govern the outputs from the next cycle on.
- R3: In mode 00 (stopped), `sub_en_o` stays 0 whatever the counts, and `rd_inhibit_o` is 0 for fields started in this mode.
- R4: In mode 01 with `svd`=0, `sub_en_o` is 1 exactly while the line index L satisfies `lines_i-(shd+1) <= L < lines_i`, in every field.
- R5: When `shd+1` is at least `lines_i`, SUB is enabled from line 0 up to `lines_i-1`. At and after line index `lines_i`, it is 0.
- R6: In mode 01 with `svd`>=1, a span begins at the first field strobe seen while no span runs. That strobe starts field 0 and raises `busy_o`. The strobe that ends field `svd` clears `busy_o`, and the field it opens lies outside any span, with no SUB. The next field strobe starts a new span.
- R7: Within a span, SUB follows the R4 line window only in the field whose index equals `spl`. Fields are counted 0,1,… from the span start. If `spl` > `svd`, no SUB is produced in the span.
- R8: A load strobe while `busy_o` is 1 has no effect on the stored settings.
- R9: In mode 10 (readout hold), `sub_en_o` stays 0. `rd_inhibit_o` is 1 for each field begun by a field strobe while this mode is stored, and it changes only at field strobes.
- R10: Mode 11 behaves as stopped: no SUB, no inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vd_i | input | 1 | Field start strobe, one cycle |
| hd_i | input | 1 | Line start strobe, one cycle |
| mode_i | input | 2 | Shutter mode: 00 stop, 01 shutter, 10 readout hold, 11 treated as stop |
| svd_i | input | 8 | Extra fields of exposure (0 = within one field) |
| shd_i | input | 10 | SUB line count minus one |
| spl_i | input | 8 | Span field index that receives SUB |
| load_i | input | 1 | Write strobe for the four settings |
| lines_i | input | 11 | Readout line index of a field |
| sub_en_o | output | 1 | SUB enable for the current line |
| rd_inhibit_o | output | 1 | Suppress readout pulses this field |
| busy_o | output | 1 | Long-exposure span in progress; loads refused |

## Verification
The short-exposure line window is swept with a vector table. The table probes the line just outside the window, its first and last lines, and the readout index itself. It covers a single-line window and windows larger than the field, which tells an off-by-one in the start bound apart from one in the end bound. Long-exposure runs put SUB in the middle field of a three-field span and also pick a field past the span's end. A refused load is then exposed by a second span starting on its own, and an accepted load by the absence of one. Readout-hold and the reserved mode are run with a shutter count that would fire SUB in shutter mode. This shows that only mode 01 ever enables it and that the inhibit moves only at field strobes.

// File: rtl/ccd_shut_pkg.sv
package ccd_shut_pkg;
  localparam int VW = 8;   // field count width
  localparam int HW = 10;  // line count width
  localparam int LW = 11;  // line index width

  typedef enum logic [1:0] {
    SM_STOP  = 2'b00,
    SM_SPEED = 2'b01,
    SM_HOLD  = 2'b10,
    SM_RSVD  = 2'b11
  } smode_e;

  typedef struct packed {
    smode_e        mode;
    logic [VW-1:0] vcnt;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] fsel;
  } shut_cfg_t;
endpackage

// File: rtl/shut_cfg.sv
module shut_cfg
  import ccd_shut_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          busy_i,
  input  logic [1:0]    mode_i,
  input  logic [VW-1:0] svd_i,
  input  logic [HW-1:0] shd_i,
  input  logic [VW-1:0] spl_i,
  output shut_cfg_t     cfg_o
);
  shut_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{mode: SM_STOP, vcnt: '0, hcnt: '0, fsel: '0};
    end else if (load_i && !busy_i) begin
      cfg_q <= '{mode: smode_e'(mode_i), vcnt: svd_i, hcnt: shd_i, fsel: spl_i};
    end
  end

  assign cfg_o = cfg_q;

  // R8
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && load_i |=> $stable(cfg_q));
  // R2
  cfg_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && load_i |=> cfg_q.vcnt == $past(svd_i) && cfg_q.hcnt == $past(shd_i));
endmodule

// File: rtl/shut_line.sv
module shut_line
  import ccd_shut_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vd_i,
  input  logic          hd_i,
  input  logic [LW-1:0] lines_i,
  input  logic [HW-1:0] shd_i,
  output logic          win_o
);
  localparam int SW = LW + 1;

  logic [LW-1:0] line_q;
  logic [SW-1:0] reach;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    line_q <= '0;
    else if (vd_i)                  line_q <= '0;
    else if (hd_i && line_q != '1)  line_q <= line_q + 1'b1;
  end

  // line index plus remaining SUB lines must reach the readout index
  assign reach = {1'b0, line_q} + {{(SW-HW){1'b0}}, shd_i} + SW'(1);
  assign win_o = (line_q < lines_i) && (reach >= {1'b0, lines_i});

  // R4
  line_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vd_i |=> line_q == '0);
  // R4
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hd_i && !vd_i && line_q != '1 |=> line_q == $past(line_q) + 1'b1);
endmodule

// File: rtl/shut_span.sv
module shut_span
  import ccd_shut_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vd_i,
  input  shut_cfg_t     cfg_i,
  output logic          active_o,
  output logic [VW-1:0] fidx_o
);
  logic          act_q;
  logic [VW-1:0] fidx_q;
  logic          slow;

  assign slow = (cfg_i.mode == SM_SPEED) && (cfg_i.vcnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      fidx_q <= '0;
    end else if (vd_i) begin
      if (act_q) begin
        if (fidx_q == cfg_i.vcnt) begin
          act_q  <= 1'b0;
          fidx_q <= '0;
        end else begin
          fidx_q <= fidx_q + 1'b1;
        end
      end else if (slow) begin
        act_q  <= 1'b1;
        fidx_q <= '0;
      end
    end
  end

  assign active_o = act_q;
  assign fidx_o   = fidx_q;

  // R6
  fidx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fidx_q != '0 |-> act_q);
  // R6
  fidx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> fidx_q <= cfg_i.vcnt);
  // R6
  fidx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vd_i |=> $stable(fidx_q) && $stable(act_q));
endmodule

// File: rtl/ccd_shutter_seq.sv
module ccd_shutter_seq
  import ccd_shut_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vd_i,
  input  logic          hd_i,
  input  logic [1:0]    mode_i,
  input  logic [VW-1:0] svd_i,
  input  logic [HW-1:0] shd_i,
  input  logic [VW-1:0] spl_i,
  input  logic          load_i,
  input  logic [LW-1:0] lines_i,
  output logic          sub_en_o,
  output logic          rd_inhibit_o,
  output logic          busy_o
);
  shut_cfg_t     cfg;
  logic          win, span_act;
  logic [VW-1:0] fidx;
  logic          fast_fire, slow_fire;
  logic          inh_q;

  shut_cfg u_cfg (
    .clk_i, .rst_ni, .load_i, .busy_i(span_act),
    .mode_i, .svd_i, .shd_i, .spl_i, .cfg_o(cfg)
  );

  shut_line u_line (
    .clk_i, .rst_ni, .vd_i, .hd_i, .lines_i, .shd_i(cfg.hcnt), .win_o(win)
  );

  shut_span u_span (
    .clk_i, .rst_ni, .vd_i, .cfg_i(cfg), .active_o(span_act), .fidx_o(fidx)
  );

  assign fast_fire = (cfg.mode == SM_SPEED) && (cfg.vcnt == '0);
  assign slow_fire = (cfg.mode == SM_SPEED) && (cfg.vcnt != '0) && span_act &&
                     (fidx == cfg.fsel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   inh_q <= 1'b0;
    else if (vd_i) inh_q <= (cfg.mode == SM_HOLD);
  end

  assign sub_en_o     = win && (fast_fire || slow_fire);
  assign rd_inhibit_o = inh_q;
  assign busy_o       = span_act;

  // R3
  sub_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_en_o |-> cfg.mode == SM_SPEED);
  // R9
  inh_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vd_i |=> $stable(rd_inhibit_o));
  // R6
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(vd_i));
endmodule

// File: tb/sim_ccd_shutter_seq.sv
module sim_ccd_shutter_seq;
  logic        clk = 0, rst_n = 0;
  logic        vd = 0, hd = 0, load = 0;
  logic [1:0]  mode = 0;
  logic [7:0]  svd = 0, spl = 0;
  logic [9:0]  shd = 0;
  logic [10:0] lines = 11'd10;
  logic        sub_en, inhibit, busy;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  ccd_shutter_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .vd_i(vd), .hd_i(hd), .mode_i(mode),
    .svd_i(svd), .shd_i(shd), .spl_i(spl), .load_i(load), .lines_i(lines),
    .sub_en_o(sub_en), .rd_inhibit_o(inhibit), .busy_o(busy)
  );

  // {lines[10:0], shd[9:0], line index[10:0], expected sub}
  localparam logic [32:0] VEC [10] = '{
    {11'd10, 10'd2,    11'd6,  1'b0},
    {11'd10, 10'd2,    11'd7,  1'b1},
    {11'd10, 10'd2,    11'd9,  1'b1},
    {11'd10, 10'd2,    11'd10, 1'b0},
    {11'd10, 10'd0,    11'd8,  1'b0},
    {11'd10, 10'd0,    11'd9,  1'b1},
    {11'd10, 10'd20,   11'd0,  1'b1},
    {11'd5,  10'd1023, 11'd4,  1'b1},
    {11'd5,  10'd1023, 11'd5,  1'b0},
    {11'd8,  10'd3,    11'd4,  1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] m, input logic [7:0] v, input logic [9:0] h,
                     input logic [7:0] p);
    @(negedge clk);
    mode = m; svd = v; shd = h; spl = p; load = 1;
    @(negedge clk);
    load = 0;
  endtask

  task automatic field();
    @(negedge clk); vd = 1;
    @(negedge clk); vd = 0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); hd = 1;
      @(negedge clk); hd = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 sub", sub_en, 0); chk("R1 inhibit", inhibit, 0); chk("R1 busy", busy, 0);
    rst_n = 1;
    lines = 11'd10; field(); step(9);
    chk("R1 stopped after reset", sub_en, 0);

    // R4 R5 vector walk
    for (int k = 0; k < 10; k++) begin
      lines = VEC[k][32:22];
      put(2'b01, 8'd0, VEC[k][21:12], 8'd0);
      field(); step(int'(VEC[k][11:1]));
      chk($sformatf("R4/R5 vec%0d", k), sub_en, VEC[k][0]);
    end
    // R4 every field, no span
    lines = 11'd10; put(2'b01, 8'd0, 10'd2, 8'd0);
    field(); step(9); chk("R4 field a", sub_en, 1);
    field(); step(9); chk("R4 field b", sub_en, 1); chk("R4 no busy", busy, 0);

    // R3
    put(2'b00, 8'd0, 10'd5, 8'd0);
    field(); step(9);
    chk("R3 sub", sub_en, 0); chk("R3 inhibit", inhibit, 0);

    // R9
    put(2'b10, 8'd0, 10'd5, 8'd0);
    chk("R9 inhibit waits for field", inhibit, 0);
    field(); step(9);
    chk("R9 inhibit", inhibit, 1); chk("R9 sub", sub_en, 0);
    put(2'b00, 8'd0, 10'd5, 8'd0);
    chk("R9 inhibit held to field end", inhibit, 1);
    field(); chk("R9 inhibit released", inhibit, 0);

    // R10
    put(2'b11, 8'd0, 10'd5, 8'd0);
    field(); step(9);
    chk("R10 sub", sub_en, 0); chk("R10 inhibit", inhibit, 0);

    // R6 R7 R8: three-field span, SUB in field 1
    lines = 11'd4;
    put(2'b01, 8'd2, 10'd1, 8'd1);
    chk("R6 idle before span", busy, 0);
    field(); chk("R6 busy at span start", busy, 1);
    step(3); chk("R7 field0 no sub", sub_en, 0);
    put(2'b00, 8'd0, 10'd0, 8'd0); // R8: refused
    field(); step(2); chk("R7 field1 line2", sub_en, 1);
    step(1); chk("R7 field1 line3", sub_en, 1);
    step(1); chk("R7 field1 line4", sub_en, 0);
    field(); step(3); chk("R7 field2 no sub", sub_en, 0); chk("R6 busy field2", busy, 1);
    field(); chk("R6 busy cleared", busy, 0);
    step(3); chk("R6 gap field no sub", sub_en, 0);
    field(); chk("R8 refused load kept span mode", busy, 1);
    field(); field(); field(); chk("R6 second span ended", busy, 0);
    // R2: accepted load stops new spans
    put(2'b00, 8'd0, 10'd0, 8'd0);
    field(); chk("R2 load taken when idle", busy, 0);

    // R7: spl beyond span
    put(2'b01, 8'd1, 10'd1, 8'd5);
    field(); step(3); chk("R7 spl>svd field0", sub_en, 0);
    field(); step(3); chk("R7 spl>svd field1", sub_en, 0);
    field(); chk("R6 short span ended", busy, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule